// File: doc/BRIEF.md
# External Interrupt Line Controller

This block collects up to 32 asynchronous interrupt lines from outside the chip and turns them into one maskable interrupt request and one non-maskable request for a processor. Each line first passes through a two-flop synchroniser. It then goes through a per-line trigger detector, and detected events are latched into a status vector. Software configures each line independently through three bit-per-line registers. A mode bit picks level or edge sensing. The edge polarity and level polarity bits are kept in two separate registers.

Software works through a flat 32-bit register window. Mask bits are set and cleared through two write-one-to-act registers, so no read-modify-write is needed. Events are acknowledged by writing ones to a clear register. Only the configured number of lines is implemented, and the bits above it always read as zero. Software can therefore write all ones to the mode register and read it back to learn the line count. Choosing which pending line to serve is left to software.

Top module: `xirq_ctrl`

## Requirements
- R1: After reset, the mask, status, mode, edge-polarity, level-polarity and non-maskable enable bits all read 0, and both `irq_out` and `nmi_out` are 0.
- R2: A write to offset 0x00 sets every mask bit whose write-data bit is 1. Mask bits whose write-data bit is 0 keep their value. Offset 0x08 reads back the current mask.
- R3: A write to offset 0x04 clears every mask bit whose write-data bit is 1. Mask bits whose write-data bit is 0 keep their value.
- R4: Offset 0x0C reads the latched status. A write to offset 0x10 clears every status bit whose write-data bit is 1, unless that line is detecting an event in the same cycle.
- R5: When a line's bit in the mode register (offset 0x14) is 0, the line is edge sensed. Its bit in the edge register (offset 0x18) selects rising edges when 1 and falling edges when 0. Each qualifying transition sets the status bit, and a transition of the opposite direction sets nothing.
- R6: When a line's mode bit is 1, the line is level sensed. Its bit in the level register (offset 0x1C) selects active-high when 1 and active-low when 0. While the input is active the status bit is held set and a clear has no effect. A clear works once the input is inactive.
- R7: Register bits for lines at or above NLINES read back as 0 in the mode, edge, level, mask and status registers, even after all ones are written.
- R8: `irq_out` equals the OR over all lines of status AND mask, taken one clock after that value.
- R9: `nmi_out` equals line 0 status AND bit 0 of the non-maskable control register (offset 0x24), taken one clock later, whatever the mask.
- R10: An input change at the pins sets the status bit at the third rising clock edge after the change, never earlier.
- R11: Writes to the read-only mask readback and status offsets, and to unmapped offsets, change no state. Unmapped offsets and the write-only offsets 0x00, 0x04 and 0x10 read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ext_in | input | NLINES | Asynchronous external interrupt lines |
| bus_wr_en | input | 1 | Write strobe, one write per cycle it is high |
| bus_addr | input | ADDR_W | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_out | output | 1 | Combined maskable interrupt request |
| nmi_out | output | 1 | Non-maskable interrupt request from line 0 |

## Verification
An input change becomes visible in status at the third rising edge after it, and `irq_out` and `nmi_out` follow one edge later. A register write takes effect at the edge that samples the strobe, and read data follows at once. The bench drives every input on a falling edge and counts falling edges before it samples. It checks status after two edges to show it is still clear, after three to show it is set, and after four to check the request outputs. Mask and control writes are checked on the output one falling edge after the write completes. This is also how the bench shows that a status clear during an active level, or a write to a read-only offset, leaves the result unchanged.

// File: rtl/xirq_pkg.sv
package xirq_pkg;

  localparam int unsigned BUS_W = 32;

  // Register window byte offsets.
  localparam logic [7:0] OFS_SET    = 8'h00;
  localparam logic [7:0] OFS_UNSET  = 8'h04;
  localparam logic [7:0] OFS_MASKRD = 8'h08;
  localparam logic [7:0] OFS_STAT   = 8'h0C;
  localparam logic [7:0] OFS_ACK    = 8'h10;
  localparam logic [7:0] OFS_MODE   = 8'h14;
  localparam logic [7:0] OFS_EDGE   = 8'h18;
  localparam logic [7:0] OFS_LVL    = 8'h1C;
  localparam logic [7:0] OFS_NMI    = 8'h24;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_SET,
    SEL_UNSET,
    SEL_MASKRD,
    SEL_STAT,
    SEL_ACK,
    SEL_MODE,
    SEL_EDGE,
    SEL_LVL,
    SEL_NMI
  } reg_sel_e;

endpackage

// File: rtl/xirq_sync.sv
module xirq_sync #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_in;
      stage2_q <= stage1_q;
    end
  end

  assign sync_out = stage2_q;

endmodule

// File: rtl/xirq_trig.sv
module xirq_trig #(
  parameter int unsigned NLINES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] line_sync,
  input  logic [NLINES-1:0] mode_lvl,
  input  logic [NLINES-1:0] edge_rise,
  input  logic [NLINES-1:0] lvl_high,
  input  logic [NLINES-1:0] ack_bits,
  output logic [NLINES-1:0] hit,
  output logic [NLINES-1:0] status
);

  logic [NLINES-1:0] prev_q;
  logic [NLINES-1:0] status_q;
  logic [NLINES-1:0] status_d;

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    logic rise;
    logic fall;
    logic lvl_act;
    assign rise    = line_sync[i] & ~prev_q[i];
    assign fall    = ~line_sync[i] & prev_q[i];
    assign lvl_act = lvl_high[i] ? line_sync[i] : ~line_sync[i];
    assign hit[i]  = mode_lvl[i] ? lvl_act : (edge_rise[i] ? rise : fall);
  end

  // A detection in the same cycle wins over an acknowledge.
  always_comb begin
    status_d = (status_q & ~ack_bits) | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      status_q <= '0;
    end else begin
      prev_q   <= line_sync;
      status_q <= status_d;
    end
  end

  assign status = status_q;

  // R6: an active level line keeps its status bit set.
  a_r6_level_holds: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(mode_lvl) & ~($past(lvl_high) ^ $past(line_sync))) & ~status_q) == '0));

endmodule

// File: rtl/xirq_regs.sv
module xirq_regs
  import xirq_pkg::*;
#(
  parameter int unsigned NLINES = 8,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  input  logic [NLINES-1:0] status,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic [NLINES-1:0] mask,
  output logic [NLINES-1:0] mode_lvl,
  output logic [NLINES-1:0] edge_rise,
  output logic [NLINES-1:0] lvl_high,
  output logic [NLINES-1:0] ack_bits,
  output logic              nmi_en
);

  reg_sel_e          sel;
  logic [NLINES-1:0] wbits;
  logic              unused_wdata;

  logic [NLINES-1:0] mask_q, mask_d;
  logic [NLINES-1:0] mode_q, mode_d;
  logic [NLINES-1:0] edge_q, edge_d;
  logic [NLINES-1:0] lvl_q,  lvl_d;
  logic              nmi_q,  nmi_d;

  assign wbits        = bus_wdata[NLINES-1:0];
  assign unused_wdata = ^bus_wdata;

  always_comb begin
    sel = SEL_NONE;
    if      (bus_addr == ADDR_W'(OFS_SET))    sel = SEL_SET;
    else if (bus_addr == ADDR_W'(OFS_UNSET))  sel = SEL_UNSET;
    else if (bus_addr == ADDR_W'(OFS_MASKRD)) sel = SEL_MASKRD;
    else if (bus_addr == ADDR_W'(OFS_STAT))   sel = SEL_STAT;
    else if (bus_addr == ADDR_W'(OFS_ACK))    sel = SEL_ACK;
    else if (bus_addr == ADDR_W'(OFS_MODE))   sel = SEL_MODE;
    else if (bus_addr == ADDR_W'(OFS_EDGE))   sel = SEL_EDGE;
    else if (bus_addr == ADDR_W'(OFS_LVL))    sel = SEL_LVL;
    else if (bus_addr == ADDR_W'(OFS_NMI))    sel = SEL_NMI;
  end

  always_comb begin
    mask_d   = mask_q;
    mode_d   = mode_q;
    edge_d   = edge_q;
    lvl_d    = lvl_q;
    nmi_d    = nmi_q;
    ack_bits = '0;
    if (bus_wr_en) begin
      case (sel)
        SEL_SET:   mask_d   = mask_q | wbits;
        SEL_UNSET: mask_d   = mask_q & ~wbits;
        SEL_ACK:   ack_bits = wbits;
        SEL_MODE:  mode_d   = wbits;
        SEL_EDGE:  edge_d   = wbits;
        SEL_LVL:   lvl_d    = wbits;
        SEL_NMI:   nmi_d    = bus_wdata[0];
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      mode_q <= '0;
      edge_q <= '0;
      lvl_q  <= '0;
      nmi_q  <= 1'b0;
    end else begin
      mask_q <= mask_d;
      mode_q <= mode_d;
      edge_q <= edge_d;
      lvl_q  <= lvl_d;
      nmi_q  <= nmi_d;
    end
  end

  always_comb begin
    case (sel)
      SEL_MASKRD: bus_rdata = BUS_W'(mask_q);
      SEL_STAT:   bus_rdata = BUS_W'(status);
      SEL_MODE:   bus_rdata = BUS_W'(mode_q);
      SEL_EDGE:   bus_rdata = BUS_W'(edge_q);
      SEL_LVL:    bus_rdata = BUS_W'(lvl_q);
      SEL_NMI:    bus_rdata = BUS_W'(nmi_q);
      default:    bus_rdata = '0;
    endcase
  end

  assign mask      = mask_q;
  assign mode_lvl  = mode_q;
  assign edge_rise = edge_q;
  assign lvl_high  = lvl_q;
  assign nmi_en    = nmi_q;

  // R2: written ones become set, zeros leave the mask alone.
  a_r2_set_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_en && sel == SEL_SET) |=> ((mask_q & $past(wbits)) == $past(wbits)));
  a_r2_set_zeros_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_en && sel == SEL_SET) |=> ((mask_q & ~$past(wbits)) == ($past(mask_q) & ~$past(wbits))));

  // R3: written ones clear mask bits.
  a_r3_unset_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_en && sel == SEL_UNSET) |=> ((mask_q & $past(wbits)) == '0));

  // R11: a write to a read-only or unmapped offset leaves configuration alone.
  a_r11_ro_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_en && (sel == SEL_NONE || sel == SEL_STAT || sel == SEL_MASKRD))
    |=> ($stable(mask_q) && $stable(mode_q) && $stable(edge_q) && $stable(lvl_q) && $stable(nmi_q)));

endmodule

// File: rtl/xirq_ctrl.sv
module xirq_ctrl
  import xirq_pkg::*;
#(
  parameter int unsigned NLINES = 8,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] ext_in,
  input  logic              bus_wr_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              irq_out,
  output logic              nmi_out
);

  localparam int unsigned RST_STAGES = 2;

  logic [RST_STAGES-1:0] rst_pipe_q;
  logic                  rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[RST_STAGES-2:0], 1'b1};
  end
  assign rst_i_n = rst_pipe_q[RST_STAGES-1];

  logic [NLINES-1:0] line_sync;
  logic [NLINES-1:0] hit;
  logic [NLINES-1:0] status;
  logic [NLINES-1:0] mask;
  logic [NLINES-1:0] mode_lvl;
  logic [NLINES-1:0] edge_rise;
  logic [NLINES-1:0] lvl_high;
  logic [NLINES-1:0] ack_bits;
  logic              nmi_en;

  xirq_sync #(.WIDTH(NLINES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .async_in (ext_in),
    .sync_out (line_sync)
  );

  xirq_trig #(.NLINES(NLINES)) u_trig (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .line_sync (line_sync),
    .mode_lvl  (mode_lvl),
    .edge_rise (edge_rise),
    .lvl_high  (lvl_high),
    .ack_bits  (ack_bits),
    .hit       (hit),
    .status    (status)
  );

  xirq_regs #(.NLINES(NLINES), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .bus_wr_en (bus_wr_en),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .status    (status),
    .bus_rdata (bus_rdata),
    .mask      (mask),
    .mode_lvl  (mode_lvl),
    .edge_rise (edge_rise),
    .lvl_high  (lvl_high),
    .ack_bits  (ack_bits),
    .nmi_en    (nmi_en)
  );

  logic irq_d, irq_q;
  logic nmi_d, nmi_q;

  always_comb begin
    irq_d = |(status & mask);
    nmi_d = status[0] & nmi_en;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      irq_q <= 1'b0;
      nmi_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
      nmi_q <= nmi_d;
    end
  end

  assign irq_out = irq_q;
  assign nmi_out = nmi_q;

  // R8: request follows pending-and-enabled one clock later.
  a_r8_irq_follows: assert property (@(posedge clk) disable iff (!rst_i_n)
    1'b1 |=> (irq_out == $past(|(status & mask))));

  // R9: non-maskable request ignores the mask.
  a_r9_nmi_follows: assert property (@(posedge clk) disable iff (!rst_i_n)
    1'b1 |=> (nmi_out == $past(status[0] & nmi_en)));

  // R4: acknowledged lines without a fresh event read clear next cycle.
  a_r4_ack_clears: assert property (@(posedge clk) disable iff (!rst_i_n)
    (|ack_bits) |=> ((status & $past(ack_bits & ~hit)) == '0));

endmodule

// File: tb/xirq_ctrl_test.sv
module xirq_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int NL = 8;

  logic          clk;
  logic          rst_n;
  logic [NL-1:0] ext_in;
  logic          bus_wr_en;
  logic [7:0]    bus_addr;
  logic [31:0]   bus_wdata;
  logic [31:0]   bus_rdata;
  logic          irq_out;
  logic          nmi_out;

  int n_checks = 0;
  int n_bad    = 0;

  xirq_ctrl #(.NLINES(NL), .ADDR_W(8)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .ext_in    (ext_in),
    .bus_wr_en (bus_wr_en),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_out   (irq_out),
    .nmi_out   (nmi_out)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr_en = 1'b1;
    bus_addr  = a;
    bus_wdata = d;
    @(negedge clk);
    bus_wr_en = 1'b0;
    bus_wdata = '0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic wait_neg(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    bus_rd(8'h08, v); check("R1 mask", v, 0);
    bus_rd(8'h0C, v); check("R1 status", v, 0);
    bus_rd(8'h14, v); check("R1 mode", v, 0);
    bus_rd(8'h18, v); check("R1 edge", v, 0);
    bus_rd(8'h1C, v); check("R1 level", v, 0);
    bus_rd(8'h24, v); check("R1 nmi ctrl", v, 0);
    check("R1 irq_out", {31'b0, irq_out}, 0);
    check("R1 nmi_out", {31'b0, nmi_out}, 0);
  endtask

  task automatic t_discover;
    logic [31:0] v;
    bus_wr(8'h14, 32'hFFFF_FFFF);
    bus_rd(8'h14, v); check("R7 mode width", v, 32'h0000_00FF);
    // All lines now active-low level with inputs low.
    wait_neg(3);
    bus_rd(8'h0C, v); check("R6 active-low all", v, 32'h0000_00FF);
    check("R8 masked off", {31'b0, irq_out}, 0);
    bus_wr(8'h14, 32'h0);
    bus_wr(8'h10, 32'hFF);
    bus_rd(8'h0C, v); check("R4 clear all", v, 0);
    bus_wr(8'h18, 32'hFFFF_FFFF);
    bus_rd(8'h18, v); check("R7 edge width", v, 32'h0000_00FF);
    bus_wr(8'h1C, 32'hFFFF_FFFF);
    bus_rd(8'h1C, v); check("R7 level width", v, 32'h0000_00FF);
    bus_wr(8'h18, 32'h0);
    bus_wr(8'h1C, 32'h0);
    bus_rd(8'h0C, v); check("R5 no event", v, 0);
  endtask

  task automatic t_mask;
    logic [31:0] v;
    bus_wr(8'h00, 32'h05);
    bus_rd(8'h08, v); check("R2 set", v, 32'h05);
    bus_wr(8'h00, 32'h02);
    bus_rd(8'h08, v); check("R2 zeros keep", v, 32'h07);
    bus_wr(8'h04, 32'h04);
    bus_rd(8'h08, v); check("R3 unset", v, 32'h03);
    bus_wr(8'h00, 32'hFFFF_FF00);
    bus_rd(8'h08, v); check("R7 mask width", v, 32'h03);
    bus_rd(8'h00, v); check("R11 set reads 0", v, 0);
    bus_rd(8'h04, v); check("R11 unset reads 0", v, 0);
  endtask

  task automatic t_rise;
    logic [31:0] v;
    bus_wr(8'h18, 32'h02);
    ext_in[1] = 1'b1;
    wait_neg(2);
    bus_rd(8'h0C, v); check("R10 not yet", v, 0);
    wait_neg(1);
    bus_rd(8'h0C, v); check("R5 rising", v, 32'h02);
    check("R8 irq not yet", {31'b0, irq_out}, 0);
    wait_neg(1);
    check("R8 irq set", {31'b0, irq_out}, 1);
    bus_wr(8'h10, 32'h02);
    bus_rd(8'h0C, v); check("R4 clear edge", v, 0);
    wait_neg(1);
    check("R8 irq drop", {31'b0, irq_out}, 0);
    ext_in[1] = 1'b0;
    wait_neg(4);
    bus_rd(8'h0C, v); check("R5 falling ignored", v, 0);
  endtask

  task automatic t_fall;
    logic [31:0] v;
    ext_in[2] = 1'b1;
    wait_neg(4);
    bus_rd(8'h0C, v); check("R5 rising ignored", v, 0);
    ext_in[2] = 1'b0;
    wait_neg(3);
    bus_rd(8'h0C, v); check("R5 falling", v, 32'h04);
    bus_wr(8'h10, 32'h04);
    bus_rd(8'h0C, v); check("R4 clear fall", v, 0);
  endtask

  task automatic t_level_high;
    logic [31:0] v;
    bus_wr(8'h1C, 32'h08);
    bus_wr(8'h14, 32'h08);
    wait_neg(3);
    bus_rd(8'h0C, v); check("R6 high idle", v, 0);
    ext_in[3] = 1'b1;
    wait_neg(3);
    bus_rd(8'h0C, v); check("R6 high set", v, 32'h08);
    bus_wr(8'h10, 32'h08);
    bus_rd(8'h0C, v); check("R6 clear while active", v, 32'h08);
    wait_neg(1);
    check("R8 unmasked line", {31'b0, irq_out}, 0);
    bus_wr(8'h00, 32'h08);
    wait_neg(1);
    check("R8 after mask set", {31'b0, irq_out}, 1);
    bus_wr(8'h04, 32'h08);
    wait_neg(1);
    check("R8 after mask unset", {31'b0, irq_out}, 0);
    ext_in[3] = 1'b0;
    wait_neg(3);
    bus_wr(8'h10, 32'h08);
    bus_rd(8'h0C, v); check("R6 clear inactive", v, 0);
  endtask

  task automatic t_level_low;
    logic [31:0] v;
    ext_in[4] = 1'b1;
    wait_neg(4);
    bus_wr(8'h14, 32'h18);
    wait_neg(3);
    bus_rd(8'h0C, v); check("R6 low idle", v, 0);
    ext_in[4] = 1'b0;
    wait_neg(3);
    bus_rd(8'h0C, v); check("R6 low set", v, 32'h10);
    bus_wr(8'h10, 32'h10);
    bus_rd(8'h0C, v); check("R6 low clear held", v, 32'h10);
    ext_in[4] = 1'b1;
    wait_neg(3);
    bus_wr(8'h10, 32'h10);
    bus_rd(8'h0C, v); check("R6 low clear", v, 0);
  endtask

  task automatic t_nmi;
    logic [31:0] v;
    bus_wr(8'h04, 32'h01);
    bus_rd(8'h08, v); check("R3 unset line0", v, 32'h02);
    bus_wr(8'h18, 32'h03);
    bus_wr(8'h24, 32'h01);
    bus_rd(8'h24, v); check("R9 ctrl read", v, 1);
    ext_in[0] = 1'b1;
    wait_neg(3);
    bus_rd(8'h0C, v); check("R5 line0 rising", v, 32'h01);
    check("R9 nmi not yet", {31'b0, nmi_out}, 0);
    wait_neg(1);
    check("R9 nmi set", {31'b0, nmi_out}, 1);
    check("R8 line0 masked", {31'b0, irq_out}, 0);
    bus_wr(8'h24, 32'h0);
    wait_neg(1);
    check("R9 nmi off", {31'b0, nmi_out}, 0);
    ext_in[0] = 1'b0;
    wait_neg(3);
    bus_wr(8'h10, 32'h01);
    bus_rd(8'h0C, v); check("R4 clear line0", v, 0);
  endtask

  task automatic t_readonly;
    logic [31:0] v;
    bus_wr(8'h0C, 32'hFF);
    bus_rd(8'h0C, v); check("R11 status write", v, 0);
    bus_wr(8'h08, 32'hFF);
    bus_rd(8'h08, v); check("R11 mask readback write", v, 32'h02);
    bus_wr(8'h20, 32'hFF);
    bus_rd(8'h20, v); check("R11 unmapped read", v, 0);
    bus_rd(8'h14, v); check("R11 mode kept", v, 32'h18);
    bus_rd(8'h10, v); check("R11 clear reads 0", v, 0);
    wait_neg(1);
    check("R11 irq quiet", {31'b0, irq_out}, 0);
  endtask

  initial begin
    rst_n     = 1'b0;
    ext_in    = '0;
    bus_wr_en = 1'b0;
    bus_addr  = '0;
    bus_wdata = '0;
    wait_neg(3);
    rst_n = 1'b1;
    wait_neg(4);
    t_reset;
    t_discover;
    t_mask;
    t_rise;
    t_fall;
    t_level_high;
    t_level_low;
    t_nmi;
    t_readonly;
    $display("test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end

endmodule